// File: doc/BRIEF.md
# SPI Controller Interrupt Collector

This block gathers the interrupt sources of a serial peripheral controller and turns them into a single level-sensitive interrupt line. The FIFO logic feeds it one-cycle event pulses and two level conditions. Software reaches three 32-bit registers through a simple read/write strobe interface: a global enable, a sticky pending-status word and a per-bit enable mask.

Software edits the pending status with a toggle mask. Each written 1 flips the matching bit, so one write can raise or drop any bit. Event pulses from the datapath set their bits directly. The two receive-side level conditions are folded into the status only when the register interface is accessed.

The interrupt output is registered. It reflects the stored state one clock after that state changes.

Top module: `spi_irq_collector`

## Requirements
- R1: After `rst_n` is low, or after a cycle with `soft_rst` high, the global enable, status and enable registers read 0 and `irq_o` is low.
- R2: The global enable sits at byte address 0x1C, the status at 0x20 and the enable mask at 0x28. A write stores all 32 bits, and `rdata` shows the addressed register in the same cycle. Any other address reads 0, and writes to it change nothing.
- R3: A write to 0x20 makes each status bit equal to its old value XOR the matching `wdata` bit.
- R4: `ev_pulse[4:0]` sets status bits 6..2 in this order: bit 0 is transmit empty (status bit 2), bit 1 is transmit underrun (3), bit 2 is receive full (4), bit 3 is receive overrun (5), and bit 4 is transmit half-empty (6). The new value is readable from the next clock.
- R5: When an event pulse and a status toggle write hit the same bit in one cycle, the bit ends up set.
- R6: In any cycle with `wr_en` or `rd_en` high, `lvl_rx_nempty` is ORed into status bit 8 and `lvl_rx_full` into status bit 4. Without an access, these levels change nothing.
- R7: `irq_o` equals, one clock later, (global enable bit 31) AND ((status AND enable mask) != 0).
- R8: While global enable bit 31 is clear, `irq_o` is low in the following cycle whatever the status holds.
- R9: Status bits other than 2..6 and 8 keep whatever a toggle write leaves in them. No event or level ever touches them.
- R10: With no access, no event pulse and no soft reset, the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of all registers and the output |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register (combinational) |
| ev_pulse | input | 5 | Single-cycle event pulses, mapped to status bits 6..2 |
| lvl_rx_nempty | input | 1 | Receive FIFO holds data |
| lvl_rx_full | input | 1 | Receive FIFO is full |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume the strobes, events and levels are stable and known at every rising edge, and that a soft reset wins over any access in the same cycle. They also assume event pulses reach the status whether or not the interface is accessed. The stimulus drives every input on the falling edge, so nothing moves near the sampling edge. Random cycles use a fixed seed and pick addresses from the three mapped offsets plus two unmapped ones. Events are kept sparse so that toggle writes both set and clear bits, and directed cycles force the event-versus-toggle collision and the masked-global-enable case.

// File: rtl/spi_irq_collector.sv
module spi_irq_collector #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] GIE_ADDR  = 'h1C,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h20,
  parameter logic [ADDR_W-1:0] IEN_ADDR  = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [4:0]        ev_pulse,
  input  logic              lvl_rx_nempty,
  input  logic              lvl_rx_full,
  output logic              irq_o
);
  logic [31:0] gie_q, stat_q, ien_q, stat_d;
  logic        irq_q;

  wire access   = wr_en | rd_en;
  wire hit_gie  = (addr == GIE_ADDR);
  wire hit_stat = (addr == STAT_ADDR);
  wire hit_ien  = (addr == IEN_ADDR);

  always_comb begin
    stat_d = stat_q;
    if (wr_en && hit_stat) stat_d = stat_q ^ wdata;
    stat_d[6:2] = stat_d[6:2] | ev_pulse;
    if (access) begin
      stat_d[8] = stat_d[8] | lvl_rx_nempty;
      stat_d[4] = stat_d[4] | lvl_rx_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
    end else if (soft_rst) begin
      gie_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (wr_en && hit_gie) gie_q <= wdata;
      if (wr_en && hit_ien) ien_q <= wdata;
      irq_q <= gie_q[31] && ((stat_q & ien_q) != '0);
    end
  end

  assign rdata = hit_gie  ? gie_q  :
                 hit_stat ? stat_q :
                 hit_ien  ? ien_q  : '0;
  assign irq_o = irq_q;

  p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (gie_q == '0 && stat_q == '0 && ien_q == '0 && !irq_o));

  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && ev_pulse[1]) |=> stat_q[3]);

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && wr_en && hit_stat && wdata[5] && ev_pulse[3]) |=> stat_q[5]);

  p_level_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && access && lvl_rx_nempty) |=> stat_q[8]);

  p_no_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ien_q) == '0) |=> !irq_o);

  p_gie_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q[31] |=> !irq_o);

  p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !access && ev_pulse == '0) |=> $stable(stat_q));
endmodule

// File: tb/spi_irq_collector_bench.sv
`timescale 1ns/1ps
module spi_irq_collector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  ev_pulse = '0;
  logic        lvl_rx_nempty = 1'b0, lvl_rx_full = 1'b0;
  logic        irq_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_gie = '0, m_stat = '0, m_ien = '0;
  logic        m_irq = 1'b0;

  always #2.5 clk = ~clk;

  spi_irq_collector u_spi_irq_collector (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ev_pulse(ev_pulse),
    .lvl_rx_nempty(lvl_rx_nempty), .lvl_rx_full(lvl_rx_full), .irq_o(irq_o));

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h1C:   return m_gie;
      8'h20:   return m_stat;
      8'h28:   return m_ien;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d,
                      input logic [4:0] ev, input logic ln, input logic lf, input logic s,
                      input string tag);
    logic [31:0] ns;
    logic        nirq;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; ev_pulse = ev;
    lvl_rx_nempty = ln; lvl_rx_full = lf; soft_rst = s;
    #1;
    if (r) check(tag, rdata, exp_read(a));
    check("R7", {31'b0, irq_o}, {31'b0, m_irq});
    @(posedge clk);
    #1;
    nirq = m_gie[31] && ((m_stat & m_ien) != 0);
    ns = m_stat;
    if (w && a == 8'h20) ns = ns ^ d;
    ns[6:2] = ns[6:2] | ev;
    if (w || r) begin ns[8] = ns[8] | ln; ns[4] = ns[4] | lf; end
    if (w && a == 8'h1C) m_gie = d;
    if (w && a == 8'h28) m_ien = d;
    m_stat = ns; m_irq = nirq;
    if (s) begin m_gie = '0; m_stat = '0; m_ien = '0; m_irq = 1'b0; end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(0, 1, a, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1, 0, a, d, 0, 0, 0, 0, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #600us;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] addrs [5];
    void'($urandom(32'd1234));
    addrs = '{8'h1C, 8'h20, 8'h28, 8'h24, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h1C, "R1"); rd(8'h20, "R1"); rd(8'h28, "R1");
    // R2 register placement
    wr(8'h1C, 32'h8000_0000, "R2"); wr(8'h28, 32'h0000_0104, "R2");
    rd(8'h1C, "R2"); rd(8'h28, "R2");
    // R3 toggle set then clear, R7 follows
    wr(8'h20, 32'h0000_0100, "R3"); rd(8'h20, "R3"); idle("R7"); idle("R7");
    wr(8'h20, 32'h0000_0100, "R3"); rd(8'h20, "R3"); idle("R7");
    // R2 unmapped write ignored
    wr(8'h24, 32'hFFFF_FFFF, "R2"); rd(8'h24, "R2"); rd(8'h20, "R2"); rd(8'h1C, "R2");
    // R4 receive-full pulse without access
    step(0, 0, 0, 0, 5'b00100, 0, 0, 0, "R4"); rd(8'h20, "R4"); idle("R7");
    // R5 event wins over clearing toggle on bit 3
    step(0, 0, 0, 0, 5'b00010, 0, 0, 0, "R5");
    step(1, 0, 8'h20, 32'h0000_0008, 5'b00010, 0, 0, 0, "R5"); rd(8'h20, "R5");
    // R6 level ignored without access, captured on access
    wr(8'h20, m_stat, "R6");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R6"); rd(8'h20, "R6");
    step(0, 1, 8'h20, 0, 0, 1, 0, 0, "R6"); rd(8'h20, "R6");
    // R8 global enable off masks output
    wr(8'h1C, 32'h7FFF_FFFF, "R8"); idle("R8"); idle("R8");
    // R9 unlisted bits hold toggled values
    wr(8'h20, 32'h8000_0001, "R9"); step(0, 1, 8'h20, 0, 5'b11111, 1, 1, 0, "R9"); rd(8'h20, "R9");
    // R1 soft reset
    wr(8'h1C, 32'h8000_0000, "R1"); step(1, 0, 8'h28, 32'hFFFF_FFFF, 0, 0, 0, 1, "R1");
    rd(8'h1C, "R1"); rd(8'h20, "R1"); rd(8'h28, "R1");
    // Random traffic: R2 R3 R4 R6 R7 R10
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [4:0] ev;
      a = addrs[$urandom_range(0, 4)];
      ev = 5'($urandom) & 5'($urandom) & 5'($urandom);
      step($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, a,
           ($urandom_range(0, 1) ? 32'h8000_0000 : 32'h0) | ($urandom & 32'h0000_01FC),
           ev, $urandom_range(0, 1), $urandom_range(0, 3) == 0,
           $urandom_range(0, 199) == 0, "R10");
    end
    finish_run();
  end
endmodule